// File: doc/BRIEF.md
# Four-Mode General-Purpose Pad Controller

This block is the digital side of 32 general-purpose I/O lines, grouped as four ports of eight pins. Each pin takes an output data bit from the rest of the chip and a two-bit mode from two per-port configuration registers. From these it drives two pad controls: a strong pull-up enable and a pull-down enable. The four modes are quasi-bidirectional, push-pull, high-impedance and open-drain. The block also returns the pin levels through a two-stage synchroniser, one port at a time, on a read bus.

Each pin is a small state machine with five states. PS_OFF drives nothing and is the reset state. PS_LOW enables only the pull-down. PS_BOOST enables the strong pull-up for one cycle. PS_RELEASE drives nothing and lets the external resistor hold the pin high. PS_DRIVE_HI holds the strong pull-up on. On every clock the next state follows from the mode and the output bit. With the bit at 0, every mode except high-impedance goes to PS_LOW, and high-impedance always goes to PS_OFF. Push-pull with the bit at 1 goes to PS_DRIVE_HI, and open-drain with the bit at 1 goes to PS_RELEASE. In quasi-bidirectional mode, a bit at 1 goes to PS_BOOST when the bit was 0 on the previous clock and to PS_RELEASE otherwise. Pins 4 to 7 of port 1 carry a two-wire serial bus and are held in open-drain mode whatever their configuration says.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While reset is asserted and before the first clock after it, every pull-up and pull-down enable is 0 and the read bus is 0. All configuration bits reset to 0, which is quasi-bidirectional mode.
- R2: A write with `wr_en` high goes to the port in `wr_addr[2:1]`. It loads register A when `wr_addr[0]` is 0 and register B when it is 1. Bit j of that register belongs to pin 8*port+j. The pin's mode is {B,A}: 00 quasi-bidirectional, 01 push-pull, 10 high-impedance, 11 open-drain. A write sampled at one clock edge controls the pads from the next edge on.
- R3: In push-pull mode, the pull-up enable equals the output bit and the pull-down enable is its inverse.
- R4: In open-drain mode, the pull-up enable is 0 and the pull-down enable is the inverse of the output bit.
- R5: In high-impedance mode, both enables are 0.
- R6: In quasi-bidirectional mode, an output bit of 0 enables only the pull-down. An output bit that changes from 0 to 1 enables only the pull-up for exactly one clock, after which both enables are 0 while the bit stays 1.
- R7: The previous output bit is tracked in every mode. A pin that enters quasi-bidirectional mode with its output bit already at 1 gets no pull-up pulse.
- R8: Pins 12 to 15 (port 1, bits 4 to 7) behave as open-drain for every configuration value.
- R9: No pin ever has its pull-up and pull-down enabled in the same cycle.
- R10: `rd_data` shows the pin levels of the port chosen by `rd_sel`, as sampled two clock edges earlier. `rd_sel` selects without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Port index in [2:1], register select in [0] (0 = A, 1 = B) |
| wr_data | input | 8 | Configuration data |
| pin_dout | input | 32 | Output data bit per pin |
| pin_in | input | 32 | Raw pin levels from the pads |
| rd_sel | input | 2 | Port whose synchronised levels appear on rd_data |
| rd_data | output | 8 | Synchronised pin levels of the selected port |
| pu_en | output | 32 | Strong pull-up enable per pin |
| pd_en | output | 32 | Pull-down enable per pin |

## Verification
The pad enables are registered, so they answer the output bit and mode that were present at the previous clock edge. A configuration write therefore shows at the pads one edge after it is sampled, and a pin level shows on `rd_data` two edges after it is applied. The bench changes its inputs on the falling edge and compares the outputs at the following falling edge against a model that it steps once per rising edge. The model keeps its own registers, previous bits and synchroniser stages, so every result is checked in the cycle it is due and no earlier.

// File: rtl/gpio_pad_pkg.sv
`timescale 1ns/1ps
package gpio_pad_pkg;

    typedef enum logic [1:0] {
        MODE_QUASI      = 2'b00,
        MODE_PUSHPULL   = 2'b01,
        MODE_HIZ        = 2'b10,
        MODE_OPEN_DRAIN = 2'b11
    } pad_mode_e;

    typedef enum logic [2:0] {
        PS_OFF      = 3'd0,
        PS_LOW      = 3'd1,
        PS_BOOST    = 3'd2,
        PS_RELEASE  = 3'd3,
        PS_DRIVE_HI = 3'd4
    } pad_state_e;

endpackage

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
module gpio_cfg_regs #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    localparam int PIDX_W   = $clog2(NUM_PORTS),
    localparam int ADDR_W   = PIDX_W + 1,
    localparam int NUM_PINS = NUM_PORTS * PORT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PORT_W-1:0]   wr_data,
    output logic [NUM_PINS-1:0] cfg_a,
    output logic [NUM_PINS-1:0] cfg_b
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = wr_en && (wr_addr[ADDR_W-1:1] == PIDX_W'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_a[p*PORT_W +: PORT_W] <= '0;
                cfg_b[p*PORT_W +: PORT_W] <= '0;
            end else if (hit) begin
                if (wr_addr[0]) cfg_b[p*PORT_W +: PORT_W] <= wr_data;
                else            cfg_a[p*PORT_W +: PORT_W] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/gpio_pin_fsm.sv
`timescale 1ns/1ps
module gpio_pin_fsm
    import gpio_pad_pkg::*;
#(
    parameter bit LOCKED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_a,
    input  logic mode_b,
    input  logic dout_i,
    output logic pu_o,
    output logic pd_o
);

    pad_mode_e  eff_mode;
    pad_state_e state_q, state_d;
    logic       prev_dout;

    assign eff_mode = LOCKED ? MODE_OPEN_DRAIN : pad_mode_e'({mode_b, mode_a});

    always_comb begin
        state_d = PS_OFF;
        unique case (eff_mode)
            MODE_QUASI:      state_d = !dout_i ? PS_LOW
                                     : (!prev_dout ? PS_BOOST : PS_RELEASE);
            MODE_PUSHPULL:   state_d = dout_i ? PS_DRIVE_HI : PS_LOW;
            MODE_HIZ:        state_d = PS_OFF;
            MODE_OPEN_DRAIN: state_d = dout_i ? PS_RELEASE : PS_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PS_OFF;
            prev_dout <= 1'b0;
        end else begin
            state_q   <= state_d;
            prev_dout <= dout_i;
        end
    end

    always_comb begin
        pu_o = 1'b0;
        pd_o = 1'b0;
        unique case (state_q)
            PS_OFF:      ;
            PS_LOW:      pd_o = 1'b1;
            PS_BOOST:    pu_o = 1'b1;
            PS_RELEASE:  ;
            PS_DRIVE_HI: pu_o = 1'b1;
            default:     ;
        endcase
    end

    // R9
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu_o && pd_o));

    // R3
    pp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_PUSHPULL) |=> (pu_o == $past(dout_i)) && (pd_o == !$past(dout_i)));

    // R5
    hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_HIZ) |=> (!pu_o && !pd_o));

    // R6
    quasi_boost_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_QUASI && dout_i && prev_dout) |=> (!pu_o && !pd_o));

    // R6
    quasi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_QUASI && !dout_i) |=> (pd_o && !pu_o));

    if (LOCKED) begin : g_lock_chk
        // R8
        locked_no_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pu_o);
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            sync_o <= '0;
        end else begin
            stage1 <= pin_i;
            sync_o <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pad_ctrl.sv
`timescale 1ns/1ps
module gpio_pad_ctrl #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter logic [NUM_PORTS*PORT_W-1:0] LOCK_MASK = 32'h0000_F000,
    localparam int PIDX_W   = $clog2(NUM_PORTS),
    localparam int ADDR_W   = PIDX_W + 1,
    localparam int NUM_PINS = NUM_PORTS * PORT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [PORT_W-1:0]   wr_data,
    input  logic [NUM_PINS-1:0] pin_dout,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [PIDX_W-1:0]   rd_sel,
    output logic [PORT_W-1:0]   rd_data,
    output logic [NUM_PINS-1:0] pu_en,
    output logic [NUM_PINS-1:0] pd_en
);

    logic [NUM_PINS-1:0] cfg_a, cfg_b, pin_sync;

    gpio_cfg_regs #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_a   (cfg_a),
        .cfg_b   (cfg_b)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpio_pin_fsm #(.LOCKED(LOCK_MASK[i])) fsm_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_a (cfg_a[i]),
            .mode_b (cfg_b[i]),
            .dout_i (pin_dout[i]),
            .pu_o   (pu_en[i]),
            .pd_o   (pd_en[i])
        );
    end

    gpio_in_sync #(.W(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .sync_o (pin_sync)
    );

    assign rd_data = pin_sync[rd_sel*PORT_W +: PORT_W];

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (pu_en == '0 && pd_en == '0));

endmodule

// File: tb/gpio_pad_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_pad_ctrl_tb_top;

    localparam logic [31:0] LOCK = 32'h0000_F000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [31:0] pin_dout = '0;
    logic [31:0] pin_in = '0;
    logic [1:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic [31:0] pu_en, pd_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_pad_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_dout(pin_dout), .pin_in(pin_in),
        .rd_sel(rd_sel), .rd_data(rd_data), .pu_en(pu_en), .pd_en(pd_en)
    );

    // reference model state
    logic [7:0]  m_a [4];
    logic [7:0]  m_b [4];
    logic [31:0] m_prev, m_s1, m_s2, exp_pu, exp_pd;
    logic [1:0]  m_mode [32];

    function automatic logic [1:0] pad_exp(logic [1:0] mode, logic d, logic prev);
        // returns {pu, pd}; mode {B,A}: 00 quasi, 01 push-pull, 10 hi-Z, 11 open-drain
        case (mode)
            2'b00:   return d ? {~prev, 1'b0} : 2'b01;
            2'b01:   return d ? 2'b10 : 2'b01;
            2'b10:   return 2'b00;
            default: return d ? 2'b00 : 2'b01;
        endcase
    endfunction

    function automatic string tag_of(int pin);
        if (LOCK[pin]) return "R8";
        case (m_mode[pin])
            2'b00:   return "R6";
            2'b01:   return "R3";
            2'b10:   return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 4; p++) begin m_a[p] = '0; m_b[p] = '0; end
        m_prev = '0; m_s1 = '0; m_s2 = '0; exp_pu = '0; exp_pd = '0;
    endtask

    task automatic model_edge();
        for (int i = 0; i < 32; i++) begin
            logic [1:0] r;
            m_mode[i] = LOCK[i] ? 2'b11 : {m_b[i/8][i%8], m_a[i/8][i%8]};
            r = pad_exp(m_mode[i], pin_dout[i], m_prev[i]);
            exp_pu[i] = r[1];
            exp_pd[i] = r[0];
        end
        if (wr_en) begin
            if (wr_addr[0]) m_b[wr_addr[2:1]] = wr_data;
            else            m_a[wr_addr[2:1]] = wr_data;
        end
        m_prev = pin_dout;
        m_s2 = m_s1;
        m_s1 = pin_in;
    endtask

    task automatic compare_all();
        logic [31:0] diff;
        checks++;
        diff = (pu_en ^ exp_pu) | (pd_en ^ exp_pd);
        if (diff != 0) begin
            failures++;
            for (int i = 0; i < 32; i++) begin
                if (diff[i]) begin
                    $display("FAIL %s pin=%0d actual pu/pd=%b%b expected=%b%b",
                             tag_of(i), i, pu_en[i], pd_en[i], exp_pu[i], exp_pd[i]);
                    break;
                end
            end
        end
        // R9
        chk("R9", pu_en & pd_en, 32'h0);
        // R10
        chk("R10", {24'h0, rd_data}, {24'h0, m_s2[rd_sel*8 +: 8]});
    endtask

    task automatic step(logic [31:0] d, logic we, logic [2:0] a, logic [7:0] wd,
                        logic [31:0] pin, logic [1:0] rs);
        pin_dout = d; wr_en = we; wr_addr = a; wr_data = wd; pin_in = pin; rd_sel = rs;
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", pu_en, 32'h0);
        chk("R1", pd_en, 32'h0);
        chk("R1", {24'h0, rd_data}, 32'h0);
        rst_n = 1'b1;

        // R6: all quasi, output low -> pull-down everywhere
        step(32'h0, 0, 0, 0, 0, 0);
        chk("R6", pd_en, 32'hFFFF_FFFF);
        // R6/R8: rise -> one-cycle boost, locked pins stay released
        step(32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        chk("R6", pu_en, ~LOCK);
        chk("R8", pu_en & LOCK, 32'h0);
        step(32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        chk("R6", pu_en | pd_en, 32'h0);

        // R2/R3: port 0 register A = FF -> push-pull
        step(32'hFFFF_FFFF, 1, 3'b000, 8'hFF, 0, 0);
        step(32'hFFFF_FF55, 0, 0, 0, 0, 0);
        chk("R2", {24'h0, pu_en[7:0]}, 32'h55);
        chk("R3", {24'h0, pd_en[7:0]}, 32'hAA);

        // R4: port 0 register B = FF -> open-drain
        step(32'hFFFF_FF0F, 1, 3'b001, 8'hFF, 0, 0);
        step(32'hFFFF_FF0F, 0, 0, 0, 0, 0);
        chk("R4", {24'h0, pu_en[7:0]}, 32'h0);
        chk("R4", {24'h0, pd_en[7:0]}, 32'hF0);

        // R5: port 2 B = FF, A = 00 -> high-impedance
        step(32'h0, 1, 3'b101, 8'hFF, 0, 0);
        step(32'h0, 0, 0, 0, 0, 0);
        chk("R5", {24'h0, pu_en[23:16] | pd_en[23:16]}, 32'h0);

        // R7: port 3 push-pull high, then back to quasi with bit held high
        step(32'hFF00_0000, 1, 3'b110, 8'hFF, 0, 0);
        step(32'hFF00_0000, 0, 0, 0, 0, 0);
        step(32'hFF00_0000, 1, 3'b110, 8'h00, 0, 0);
        step(32'hFF00_0000, 0, 0, 0, 0, 0);
        chk("R7", {24'h0, pu_en[31:24]}, 32'h0);

        // R8: try to force locked pins to push-pull
        step(32'h0000_F000, 1, 3'b010, 8'hF0, 0, 1);
        step(32'h0000_F000, 0, 0, 0, 0, 1);
        chk("R8", pu_en & LOCK, 32'h0);

        // R10: two-edge input latency on port 1
        step(32'h0, 0, 0, 0, 32'h0000_A500, 1);
        chk("R10", {24'h0, rd_data}, 32'h0);
        step(32'h0, 0, 0, 0, 32'h0000_A500, 1);
        chk("R10", {24'h0, rd_data}, 32'hA5);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic we;
            we = ($urandom % 4) == 0;
            step(($urandom % 3 == 0) ? pin_dout ^ $urandom : pin_dout,
                 we, 3'($urandom), 8'($urandom), $urandom, 2'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule